// File: doc/BRIEF.md
# Two-Level Lookahead Adder, 16 Bits

This block adds two 16-bit operands and a carry-in in one combinational pass. It splits the operands into four 4-bit groups. Each group forms, for every bit, a generate term (both operand bits high) and a propagate term (operand bits differ). From these it builds all of its internal carries as flat AND-OR expressions of the group's own terms and its incoming carry, so no carry passes through a lower bit position on its way up. Each group also summarises itself as one group propagate and one group generate.

A second-level lookahead unit takes the four group summaries and the adder carry-in. With the same flat AND-OR form, it produces the carry into each upper group and the final carry-out. A signed-overflow flag compares the carry entering the sign bit with the carry leaving it. The block holds no state, and its outputs follow its inputs within the same evaluation.

Top module: `cla_adder16`

## Requirements
- R1: `sum_o` equals the low 16 bits of the unsigned total `a_i + b_i + cin_i`.
- R2: `cout_o` equals bit 16 of that 17-bit total.
- R3: `ovf_o` is 1 exactly when the carry into bit 15 differs from the carry out of bit 15. For two's-complement operands this is the case when `a_i[15]` equals `b_i[15]` and `sum_o[15]` differs from them.
- R4: With `a_i` = 16'hFFFF and either `b_i` = 16'h0000 with `cin_i` = 1, or `b_i` = 16'h0001 with `cin_i` = 0, the carry passes every position: `sum_o` = 16'h0000 and `cout_o` = 1.
- R5: A group whose bits generate a carry (for example `a_i` = 16'h000F, `b_i` = 16'h0001) delivers a carry into the group above whatever `cin_i` is.
- R6: When every lower group propagates, `cin_i` reaches the group above directly. For example, 16'h0FFF + 16'h0000 + 1 gives 16'h1000, with `cout_o` = 0.
- R7: The outputs depend only on the present inputs. The same inputs give the same outputs after any earlier sequence of inputs.
- R8: All-zero inputs give `sum_o` = 0, `cout_o` = 0 and `ovf_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| cout_o | output | 1 | Carry out of bit 15 |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between any input and any output. The bench drives each vector just after a rising edge of its pacing clock and samples at the following falling edge, half a period later, once all combinational paths have settled. The sweep covers every 6-bit operand pair with both carry-in values. It places these pairs once across the boundary between the two low groups and once across the sign bit. It then adds random vectors and named corner vectors, including the full carry chain and the history-independence sequence.

// File: rtl/cla_pkg.sv
package cla_pkg;
  // Summary a 4-bit group hands to the second level.
  typedef struct packed {
    logic prop;
    logic gen;
  } grp_pg_t;

  localparam int unsigned GRP_W_DEF   = 4;
  localparam int unsigned NUM_GRP_DEF = 4;
endpackage

// File: rtl/cla_carry_net.sv
// Flat lookahead network: every carry is a single OR of AND terms.
module cla_carry_net #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         c0_i,
  output logic [N:1]   carry_o,
  output logic         gen_all_o,
  output logic         prop_all_o
);
  for (genvar j = 1; j <= N; j++) begin : g_carry
    logic [j:0] terms;
    assign terms[0] = (&prop_i[j-1:0]) & c0_i;
    for (genvar k = 0; k < j; k++) begin : g_term
      if (k == j - 1) begin : g_top
        assign terms[k+1] = gen_i[k];
      end else begin : g_mid
        assign terms[k+1] = gen_i[k] & (&prop_i[j-1:k+1]);
      end
    end
    assign carry_o[j] = |terms;
  end

  logic [N-1:0] gen_terms;
  for (genvar k = 0; k < N; k++) begin : g_gall
    if (k == N - 1) begin : g_top
      assign gen_terms[k] = gen_i[k];
    end else begin : g_mid
      assign gen_terms[k] = gen_i[k] & (&prop_i[N-1:k+1]);
    end
  end
  assign gen_all_o  = |gen_terms;
  assign prop_all_o = &prop_i;
endmodule

// File: rtl/cla_group.sv
module cla_group
  import cla_pkg::*;
#(
  parameter int unsigned GRP_W    = GRP_W_DEF,
  parameter bit          SIGN_GRP = 1'b0
) (
  input  logic [GRP_W-1:0] a_i,
  input  logic [GRP_W-1:0] b_i,
  input  logic             cin_i,
  output logic [GRP_W-1:0] sum_o,
  output grp_pg_t          pg_o,
  output logic             ovf_o
);
  logic [GRP_W-1:0] bit_g, bit_p;
  logic [GRP_W:1]   c_int;
  logic [GRP_W:0]   c_all;
  logic             g_all, p_all;

  assign bit_g = a_i & b_i;
  assign bit_p = a_i ^ b_i;

  cla_carry_net #(.N(GRP_W)) u_net (
    .gen_i      (bit_g),
    .prop_i     (bit_p),
    .c0_i       (cin_i),
    .carry_o    (c_int),
    .gen_all_o  (g_all),
    .prop_all_o (p_all)
  );

  assign c_all = {c_int, cin_i};
  assign sum_o = bit_p ^ c_all[GRP_W-1:0];
  assign pg_o  = '{prop: p_all, gen: g_all};

  if (SIGN_GRP) begin : g_sign
    assign ovf_o = c_all[GRP_W-1] ^ c_all[GRP_W];
  end else begin : g_plain
    assign ovf_o = 1'b0;
  end

  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i})) begin
      AST_GRP_GEN_CARRY: assert (!g_all || c_int[GRP_W])
        else $error("group generate without carry out"); // R5
      AST_GRP_PROP_CARRY: assert (!(p_all && cin_i) || c_int[GRP_W])
        else $error("group propagate dropped carry"); // R6
    end
  end
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead
  import cla_pkg::*;
#(
  parameter int unsigned NUM_GRP = NUM_GRP_DEF
) (
  input  grp_pg_t [NUM_GRP-1:0] pg_i,
  input  logic                  cin_i,
  output logic [NUM_GRP-1:0]    grp_cin_o,
  output logic                  cout_o
);
  logic [NUM_GRP-1:0] gg, gp;
  logic [NUM_GRP:1]   c_lvl;
  logic               big_g, big_p;

  for (genvar i = 0; i < NUM_GRP; i++) begin : g_split
    assign gg[i] = pg_i[i].gen;
    assign gp[i] = pg_i[i].prop;
  end

  cla_carry_net #(.N(NUM_GRP)) u_net (
    .gen_i      (gg),
    .prop_i     (gp),
    .c0_i       (cin_i),
    .carry_o    (c_lvl),
    .gen_all_o  (big_g),
    .prop_all_o (big_p)
  );

  assign grp_cin_o = {c_lvl[NUM_GRP-1:1], cin_i};
  assign cout_o    = c_lvl[NUM_GRP];

  always_comb begin
    if (!$isunknown({gg, gp, cin_i})) begin
      AST_LA_COUT: assert (cout_o == (big_g | (big_p & cin_i)))
        else $error("second-level carry out mismatch"); // R2
      for (int i = 1; i < NUM_GRP; i++) begin
        AST_LA_STEP: assert (grp_cin_o[i] == (gg[i-1] | (gp[i-1] & grp_cin_o[i-1])))
          else $error("group carry %0d mismatch", i); // R6
      end
    end
  end
endmodule

// File: rtl/cla_adder16.sv
module cla_adder16
  import cla_pkg::*;
#(
  parameter int unsigned GRP_W   = GRP_W_DEF,
  parameter int unsigned NUM_GRP = NUM_GRP_DEF
) (
  input  logic [GRP_W*NUM_GRP-1:0] a_i,
  input  logic [GRP_W*NUM_GRP-1:0] b_i,
  input  logic                     cin_i,
  output logic [GRP_W*NUM_GRP-1:0] sum_o,
  output logic                     cout_o,
  output logic                     ovf_o
);
  localparam int unsigned W = GRP_W * NUM_GRP;

  grp_pg_t [NUM_GRP-1:0] grp_pg;
  logic    [NUM_GRP-1:0] grp_cin;
  logic    [NUM_GRP-1:0] grp_ovf;

  for (genvar i = 0; i < NUM_GRP; i++) begin : g_grp
    cla_group #(
      .GRP_W    (GRP_W),
      .SIGN_GRP (i == NUM_GRP - 1)
    ) u_grp (
      .a_i   (a_i[i*GRP_W +: GRP_W]),
      .b_i   (b_i[i*GRP_W +: GRP_W]),
      .cin_i (grp_cin[i]),
      .sum_o (sum_o[i*GRP_W +: GRP_W]),
      .pg_o  (grp_pg[i]),
      .ovf_o (grp_ovf[i])
    );
  end

  cla_lookahead #(.NUM_GRP(NUM_GRP)) u_la (
    .pg_i      (grp_pg),
    .cin_i     (cin_i),
    .grp_cin_o (grp_cin),
    .cout_o    (cout_o)
  );

  assign ovf_o = |grp_ovf;

  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i})) begin
      AST_SUM_TOTAL: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}))
        else $error("sum/carry mismatch"); // R1
      AST_OVF_SIGNS: assert (ovf_o == ((a_i[W-1] == b_i[W-1]) && (sum_o[W-1] != a_i[W-1])))
        else $error("overflow flag mismatch"); // R3
    end
  end
endmodule

// File: tb/sim_cla_adder16.sv
module sim_cla_adder16;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int WATCHDOG_CYC = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [W-1:0] a = '0, b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] s;
  logic         co, ov;
  int  n_chk = 0, n_err = 0;
  bit  done = 1'b0;

  cla_adder16 u0 (
    .a_i(a), .b_i(b), .cin_i(cin),
    .sum_o(s), .cout_o(co), .ovf_o(ov)
  );

  task automatic check_vec(input logic [W-1:0] va, input logic [W-1:0] vb,
                           input logic vc, input string tag);
    logic [W:0] want;
    logic       want_ov;
    @(posedge clk); #1;
    a = va; b = vb; cin = vc;
    @(negedge clk);
    want    = {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc};
    want_ov = (va[W-1] == vb[W-1]) && (want[W-1] != va[W-1]);
    n_chk++;
    if ({co, s, ov} !== {want, want_ov}) begin
      n_err++;
      $display("FAIL %s a=%h b=%h cin=%b: got cout=%b sum=%h ovf=%b, expected cout=%b sum=%h ovf=%b",
               tag, va, vb, vc, co, s, ov, want[W], want[W-1:0], want_ov);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: run hung, got no completion, expected completion");
      report();
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    check_vec(16'h0000, 16'h0000, 1'b0, "R8 zero inputs");
    // R4 full carry chain
    check_vec(16'hFFFF, 16'h0000, 1'b1, "R4 ones plus cin");
    check_vec(16'hFFFF, 16'h0001, 1'b0, "R4 ones plus one");
    // R5 group generate
    check_vec(16'h000F, 16'h0001, 1'b0, "R5 group0 generate cin0");
    check_vec(16'h000F, 16'h0001, 1'b1, "R5 group0 generate cin1");
    check_vec(16'h00F0, 16'h0010, 1'b0, "R5 group1 generate");
    // R6 group propagate
    check_vec(16'h0FFF, 16'h0000, 1'b1, "R6 three groups propagate");
    check_vec(16'h00FF, 16'hFF00, 1'b1, "R6 all propagate");
    // R3 sign boundary
    check_vec(16'h7FFF, 16'h0001, 1'b0, "R3 positive overflow");
    check_vec(16'h8000, 16'h8000, 1'b0, "R3 negative overflow");
    check_vec(16'h8000, 16'hFFFF, 1'b0, "R3 negative wrap");
    check_vec(16'h7FFF, 16'h8000, 1'b1, "R3 mixed signs");
    check_vec(16'h7FFF, 16'h7FFF, 1'b1, "R3 max positive sum");
    // R1 R2 alternating patterns
    check_vec(16'hAAAA, 16'h5555, 1'b0, "R1 alternating cin0");
    check_vec(16'hAAAA, 16'h5555, 1'b1, "R2 alternating cin1");
    check_vec(16'hAAAA, 16'hAAAA, 1'b0, "R2 alternating same");
    // R7 history independence
    check_vec(16'h1234, 16'h4321, 1'b0, "R7 first visit");
    check_vec(16'hFFFF, 16'hFFFF, 1'b1, "R7 disturb");
    check_vec(16'h1234, 16'h4321, 1'b0, "R7 revisit");
    // R1 R2 R3 exhaustive 6-bit windows across a group edge and the sign bit
    for (int off = 2; off <= 10; off += 8) begin
      for (int x = 0; x < 64; x++) begin
        for (int y = 0; y < 64; y++) begin
          for (int c = 0; c < 2; c++) begin
            check_vec(W'(x) << off, W'(y) << off, c[0], "R1 window sweep");
          end
        end
      end
    end
    for (int r = 0; r < 3000; r++) begin
      check_vec(W'($urandom), W'($urandom), 1'($urandom), "R2 random");
    end
    done = 1'b1;
    report();
  end
endmodule